// File: doc/BRIEF.md
# Shift-and-Count Ones Counter

This block reports how many bits of a small input word are set. A datapath holds a shift register and a narrow counter. A separate controller with one flip-flop per state sequences the datapath over three phases: idle, scan and finished. While idle, the datapath keeps reloading the register from the input word and keeps clearing the counter. A start request moves the controller into the scan phase.

During the scan phase the register moves one place toward bit 0 on every clock. The counter advances on each scan cycle in which the bit leaving position 0 is a one. The scan ends as soon as the register holds only zeroes, so it never takes more cycles than the position of the highest set bit requires. The controller then raises `done` and holds the result on `count` for as long as `start` stays high. Dropping `start` returns the block to idle.

The start and done pins are plain level-sensitive control, not a valid/ready stream. The handshake is: hold `start` high until `done` rises, keep it high while reading `count`, then release it. The counter is only `CNT_W` bits wide. At the default widths (4-bit data, 2-bit counter) an all-ones word gives a true count of 4, which wraps to 0.

Top module: `bitcnt_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done` is 0 and `count` is 0. The controller is in its idle state.
- R2: Every clock edge in the idle state copies `data` into the shift register and clears the counter. `count` reads 0 from the second edge after a return to idle.
- R3: If `start` is 1 at an edge in the idle state, that edge captures `data` and the next cycle is a scan cycle. If `start` is 0, the block stays idle.
- R4: Every scan cycle shifts the register right by one position and fills bit DATA_W-1 with 0.
- R5: The counter advances by one on a scan cycle only when bit 0 of the register is 1 in that cycle.
- R6: A scan cycle that finds the register all zeroes moves the controller to the finished state. `done` first reads 1 k edges after the capturing edge, where k = 1 for a zero word and k = (index of highest set bit) + 2 otherwise.
- R7: In the finished state, `count` equals the number of ones in the captured word modulo 2^CNT_W. At the defaults, 1111 gives 0.
- R8: While `start` stays 1 in the finished state, `done` stays 1 and `count` does not change.
- R9: If `start` is 0 at an edge in the finished state, `done` reads 0 after that edge.
- R10: Changes on `data` after the capturing edge have no effect on the result.
- R11: Exactly one controller state flip-flop is set in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; controller and datapath share its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request; hold high until done and while reading count |
| data | input | DATA_W | Word whose set bits are counted |
| done | output | 1 | Result valid |
| count | output | CNT_W | Number of set bits, modulo 2^CNT_W |

## Verification
The result is due k edges after the capturing edge, where k is 1 for a zero word and otherwise the highest set-bit index plus 2. The bench drives inputs on falling edges and counts rising edges from the capture until `done` reads 1. It flags an error if that edge number differs from k + 1, counting the capturing edge itself. After a release of `start`, `done` is checked one edge later and the cleared count two edges later, which is when the reload in idle takes effect.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;
  localparam int NUM_ST  = 3;
  localparam int ST_IDLE = 0;
  localparam int ST_SCAN = 1;
  localparam int ST_FIN  = 2;
  typedef logic [NUM_ST-1:0] state_t;
  localparam state_t RESET_STATE = state_t'(1) << ST_IDLE;
endpackage

// File: rtl/bitcnt_datapath.sv
module bitcnt_datapath #(
  parameter int DATA_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_en,
  input  logic              cnt_en,
  input  logic [DATA_W-1:0] data,
  output logic              lsb,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (load) begin
      sreg_q <= data;
    end else if (shift_en) begin
      sreg_q <= {1'b0, sreg_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign lsb   = sreg_q[0];
  assign empty = ~|sreg_q;
  assign count = cnt_q;

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0)); // R2
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load) |=> (sreg_q == ($past(sreg_q) >> 1))); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !load) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/bitcnt_control.sv
module bitcnt_control
  import bitcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lsb,
  input  logic empty,
  output logic load,
  output logic shift_en,
  output logic cnt_en,
  output logic done
);
  state_t state_q, state_d;

  always_comb begin
    state_d          = '0;
    state_d[ST_IDLE] = (state_q[ST_IDLE] & ~start) | (state_q[ST_FIN] & ~start);
    state_d[ST_SCAN] = (state_q[ST_IDLE] &  start) | (state_q[ST_SCAN] & ~empty);
    state_d[ST_FIN]  = (state_q[ST_SCAN] &  empty) | (state_q[ST_FIN] & start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RESET_STATE;
    else        state_q <= state_d;
  end

  assign load     = state_q[ST_IDLE];
  assign shift_en = state_q[ST_SCAN];
  assign cnt_en   = state_q[ST_SCAN] & lsb;
  assign done     = state_q[ST_FIN];

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1); // R11
  AST_START_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[ST_IDLE] && start) |=> state_q[ST_SCAN]); // R3
  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[ST_IDLE] && !start) |=> state_q[ST_IDLE]); // R3
  AST_SCAN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[ST_SCAN] && empty) |=> done); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done); // R8
  AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R9
endmodule

// File: rtl/bitcnt_top.sv
module bitcnt_top #(
  parameter int DATA_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              done,
  output logic [CNT_W-1:0]  count
);
  logic load, shift_en, cnt_en, lsb, empty;

  bitcnt_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lsb(lsb), .empty(empty),
    .load(load), .shift_en(shift_en), .cnt_en(cnt_en), .done(done)
  );

  bitcnt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
    .cnt_en(cnt_en), .data(data), .lsb(lsb), .empty(empty), .count(count)
  );

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> $stable(count)); // R8
endmodule

// File: tb/sim_bitcnt_top.sv
module sim_bitcnt_top;
  localparam int DW = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] data = '0;
  logic done;
  logic [CW-1:0] count;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bitcnt_top #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .data(data),
    .done(done), .count(count)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones(input int w);
    int n = 0;
    for (int i = 0; i < DW; i++) n += (w >> i) & 1;
    return n;
  endfunction

  function automatic int due(input int w);
    int k = 1;
    for (int i = 0; i < DW; i++) if ((w >> i) & 1) k = i + 2;
    return k;
  endfunction

  task automatic run(input int w, input bit scramble);
    int edges = 0;
    int held;
    @(negedge clk);
    data = DW'(w);
    start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    if (scramble) data = ~DW'(w); // R10 stimulus
    while (!done && edges < 20) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    check(scramble ? "R10 latency" : "R6 latency", edges, due(w) + 1);
    check(scramble ? "R10 count" : "R7 count", int'(count), ones(w) % (1 << CW));
    held = int'(count);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      check("R8 done held", int'(done), 1);
      check("R8 count held", int'(count), held);
    end
    start = 1'b0;
    @(negedge clk);
    check("R9 done drop", int'(done), 0);
    @(negedge clk);
    check("R2 cleared", int'(count), 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 count", int'(count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after", int'(done), 0);
    check("R1 count after", int'(count), 0);
    for (int c = 0; c < 3; c++) begin
      data = 4'b1011;
      @(negedge clk);
      check("R3 stays idle", int'(done), 0);
      check("R2 idle count", int'(count), 0);
    end
    for (int w = 0; w < (1 << DW); w++) run(w, 1'b0);
    run(4'b1111, 1'b0); // R7 wrap to 0
    run(4'b0101, 1'b1);
    run(4'b1000, 1'b1);
    run(4'b0000, 1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule